// File: doc/BRIEF.md
# Serial Keyboard and Mouse Frame Receiver

This block takes the two serial lines of a keyboard port and of a mouse port and turns them into bytes. Each device drives its own clock line and data line. The block brings all four lines into the system clock domain and reads the data line each time the device clock falls. A frame is one low start bit, eight data bits sent least significant bit first, an odd parity bit and one high stop bit. The finished byte goes to the output-buffer logic as a one-cycle strobe. The strobe carries a parity-error flag, a timeout flag and a flag that names the port the byte came from.

Each port has its own receiver. A receiver keeps its result until the output stage takes it. When both ports finish in the same cycle, the keyboard byte goes out first and the mouse byte goes out one cycle later. A frame that has not finished within a set number of system cycles after its start bit is replaced by the byte 0xFF with the timeout flag set. A low level on the link-enable input drops every result, so that no scan codes reach the host while the link is inhibited.

Top module: `ps2_frame_rx`

## Requirements
- R1: A frame is one start bit (0), eight data bits sent least significant bit first, a parity bit and a stop bit (1). Each bit is read on a falling edge of the device clock. A frame that completes is delivered with `rx_byte_o` equal to the eight data bits.
- R2: Parity is odd: the eight data bits and the parity bit together hold an odd number of ones. On a mismatch the byte is still delivered, with `rx_perr_o`=1. A byte with correct parity has `rx_perr_o`=0.
- R3: If the stop bit has not arrived TMO_CYC system cycles after the start-bit edge, the receiver goes back to idle and delivers 0xFF with `rx_tmo_o`=1 and `rx_perr_o`=0.
- R4: While `link_en_i` is low, completed frames and timeouts on both ports are dropped and `rx_valid_o` stays low. Delivery resumes once `link_en_i` is high again.
- R5: `rx_from_mouse_o` is 0 for a byte from the keyboard port and 1 for a byte from the mouse port.
- R6: A frame whose stop bit reads 0 is dropped without any delivery. The receiver then waits for a new start bit, and the next good frame on that port is delivered correctly.
- R7: While the receiver is idle, a falling device-clock edge with the data line high does not start a frame.
- R8: `rx_valid_o` is a one-cycle strobe. When both ports have a result in the same cycle, the keyboard byte is delivered first and the mouse byte in the next cycle.
- R9: `rx_valid_o` for a frame rises 3 to 5 system clock cycles after the falling device-clock edge that carries its stop bit.
- R10: After reset, `rx_valid_o` is low and both receivers are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kbd_clk_i | input | 1 | Keyboard port clock line |
| kbd_data_i | input | 1 | Keyboard port data line |
| mse_clk_i | input | 1 | Mouse port clock line |
| mse_data_i | input | 1 | Mouse port data line |
| link_en_i | input | 1 | Low drops all received results (link inhibited) |
| rx_valid_o | output | 1 | One-cycle strobe: a byte is delivered |
| rx_byte_o | output | 8 | Delivered byte |
| rx_perr_o | output | 1 | Delivered byte failed the odd-parity check |
| rx_tmo_o | output | 1 | Delivered byte is the timeout substitute 0xFF |
| rx_from_mouse_o | output | 1 | 1 = mouse port, 0 = keyboard port |

## Verification
A frame result is due four system clock edges after the stop-bit falling edge is driven. Two edges are spent in the synchroniser, one in the receiver's result register and one in the output register. A monitor stamps every strobe with its cycle number, and the bench compares that stamp with the cycle in which it drove the last falling edge. The window of 3 to 5 cycles is checked, and then the byte and flags are compared about twenty cycles later, well after the strobe has settled. A timeout result is due TMO_CYC cycles after the start edge, plus the same pipeline, so the bench waits TMO_CYC plus a margin before it looks. For the simultaneous case, the two stamps must differ by exactly one cycle.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] TMO_BYTE = 8'hFF;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              perr;
        logic              tmo;
    } rx_res_t;

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_i,
    input  logic ddat_i,
    output logic data_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] clk_sh;
        logic [STAGES-1:0] dat_sh;
        logic              clk_prev;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d          = st_q;
        st_d.clk_sh   = {st_q.clk_sh[STAGES-2:0], dclk_i};
        st_d.dat_sh   = {st_q.dat_sh[STAGES-2:0], ddat_i};
        st_d.clk_prev = st_q.clk_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{clk_sh: '1, dat_sh: '1, clk_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.dat_sh[STAGES-1];
    assign fall_o = st_q.clk_prev & ~st_q.clk_sh[STAGES-1];

endmodule

// File: rtl/ps2_rx_chan.sv
module ps2_rx_chan
    import ps2_rx_pkg::*;
#(
    parameter int TMO_CYC = 400000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fall_i,
    input  logic    data_i,
    input  logic    allow_i,
    input  logic    ack_i,
    output logic    pend_o,
    output rx_res_t res_o
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam int LAST_DATA = BYTE_W - 1;

    typedef struct packed {
        logic              busy;
        logic [3:0]        bit_cnt;
        logic [BYTE_W-1:0] shreg;
        logic              par;
        logic [TW-1:0]     tmo_cnt;
        logic              pend;
        rx_res_t           res;
    } chan_t;

    chan_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (ack_i) begin
            st_d.pend = 1'b0;
        end
        if (!st_q.busy) begin
            if (fall_i && !data_i) begin
                st_d.busy    = 1'b1;
                st_d.bit_cnt = '0;
                st_d.par     = 1'b0;
                st_d.tmo_cnt = '0;
            end
        end else if (fall_i) begin
            st_d.tmo_cnt = st_q.tmo_cnt + TW'(1);
            if (st_q.bit_cnt <= 4'(LAST_DATA)) begin
                st_d.shreg   = {data_i, st_q.shreg[BYTE_W-1:1]};
                st_d.par     = st_q.par ^ data_i;
                st_d.bit_cnt = st_q.bit_cnt + 4'd1;
            end else if (st_q.bit_cnt == 4'(BYTE_W)) begin
                st_d.par     = st_q.par ^ data_i;
                st_d.bit_cnt = st_q.bit_cnt + 4'd1;
            end else begin
                st_d.busy = 1'b0;
                if (data_i && allow_i) begin
                    st_d.pend     = 1'b1;
                    st_d.res.data = st_q.shreg;
                    st_d.res.perr = ~st_q.par;
                    st_d.res.tmo  = 1'b0;
                end
            end
        end else if (st_q.tmo_cnt == TW'(TMO_CYC - 1)) begin
            st_d.busy = 1'b0;
            if (allow_i) begin
                st_d.pend     = 1'b1;
                st_d.res.data = TMO_BYTE;
                st_d.res.perr = 1'b0;
                st_d.res.tmo  = 1'b1;
            end
        end else begin
            st_d.tmo_cnt = st_q.tmo_cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign res_o  = st_q.res;

    // R1: the bit counter never runs past the stop-bit slot
    p_bitcnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bit_cnt <= 4'(BYTE_W + 1));

    // R3: the frame window counter stays below its limit
    p_tmo_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tmo_cnt < TW'(TMO_CYC));

    // R3: a timeout result never carries a parity error
    p_tmo_no_perr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && st_q.res.tmo) |-> !st_q.res.perr);

    // R4: a new result only appears while the link was enabled
    p_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(allow_i));

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2_rx_pkg::*;
#(
    parameter int TMO_CYC     = 400000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kbd_clk_i,
    input  logic             kbd_data_i,
    input  logic             mse_clk_i,
    input  logic             mse_data_i,
    input  logic             link_en_i,
    output logic             rx_valid_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic             rx_perr_o,
    output logic             rx_tmo_o,
    output logic             rx_from_mouse_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] line_clk, line_dat;
    logic [NCH-1:0] fall, sdat, pend, ack;
    rx_res_t        res [NCH];

    assign line_clk = {mse_clk_i, kbd_clk_i};
    assign line_dat = {mse_data_i, kbd_data_i};

    typedef struct packed {
        logic [SYNC_STAGES-1:0] allow_sh;
        logic                   vld;
        rx_res_t                res;
        logic                   src;
    } top_t;

    top_t st_q, st_d;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .dclk_i (line_clk[g]),
            .ddat_i (line_dat[g]),
            .data_o (sdat[g]),
            .fall_o (fall[g])
        );
        ps2_rx_chan #(.TMO_CYC(TMO_CYC)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .fall_i  (fall[g]),
            .data_i  (sdat[g]),
            .allow_i (st_q.allow_sh[SYNC_STAGES-1]),
            .ack_i   (ack[g]),
            .pend_o  (pend[g]),
            .res_o   (res[g])
        );
    end

    // fixed priority: keyboard (index 0) before mouse
    assign ack[0] = pend[0];
    assign ack[1] = pend[1] & ~pend[0];

    always_comb begin
        st_d          = st_q;
        st_d.allow_sh = {st_q.allow_sh[SYNC_STAGES-2:0], link_en_i};
        st_d.vld      = |ack;
        if (ack[0]) begin
            st_d.res = res[0];
            st_d.src = 1'b0;
        end else if (ack[1]) begin
            st_d.res = res[1];
            st_d.src = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_valid_o      = st_q.vld;
    assign rx_byte_o       = st_q.res.data;
    assign rx_perr_o       = st_q.res.perr;
    assign rx_tmo_o        = st_q.res.tmo;
    assign rx_from_mouse_o = st_q.src;

    // R3: a timeout delivery always carries the substitute byte
    p_tmo_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && rx_tmo_o) |-> (rx_byte_o == TMO_BYTE));

    // R8: with both results pending, the keyboard byte goes out next
    p_kbd_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && pend[1]) |=> (rx_valid_o && !rx_from_mouse_o));

    // R8: a pending mouse result follows the keyboard strobe at once
    p_mouse_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && pend[1]) |=> pend[1]);

    // R2: the two error flags never appear together
    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !(rx_perr_o && rx_tmo_o));

endmodule

// File: tb/ps2_frame_rx_tb.sv
module ps2_frame_rx_tb;
    localparam int TMO = 2000;
    localparam int HP  = 40;
    localparam int NV  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] dclk = 2'b11;
    logic [1:0] ddat = 2'b11;
    logic link_en = 1'b1;
    logic       rx_valid_o, rx_perr_o, rx_tmo_o, rx_from_mouse_o;
    logic [7:0] rx_byte_o;

    always #2.5 clk = ~clk;

    ps2_frame_rx #(.TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .kbd_clk_i(dclk[0]), .kbd_data_i(ddat[0]),
        .mse_clk_i(dclk[1]), .mse_data_i(ddat[1]),
        .link_en_i(link_en),
        .rx_valid_o(rx_valid_o), .rx_byte_o(rx_byte_o),
        .rx_perr_o(rx_perr_o), .rx_tmo_o(rx_tmo_o),
        .rx_from_mouse_o(rx_from_mouse_o)
    );

    int cyc = 0;
    int cap_n = 0;
    logic [7:0] cap_byte [64];
    logic [2:0] cap_flg [64];
    int         cap_cyc [64];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rx_valid_o && cap_n < 64) begin
            cap_byte[cap_n] <= rx_byte_o;
            cap_flg[cap_n]  <= {rx_from_mouse_o, rx_tmo_o, rx_perr_o};
            cap_cyc[cap_n]  <= cyc;
            cap_n           <= cap_n + 1;
        end
    end

    int checks = 0;
    int fails  = 0;
    int last_fall = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] mkframe(input logic [7:0] b, input bit bad_par,
                                            input bit bad_stop);
        logic p;
        p = ~(^b) ^ bad_par;
        return {~bad_stop, p, b, 1'b0};
    endfunction

    // drive frames on the ports selected by mask; nbits limits the bit count
    task automatic send(input logic [1:0] mask, input logic [10:0] fk,
                        input logic [10:0] fm, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            if (mask[0]) ddat[0] = fk[i];
            if (mask[1]) ddat[1] = fm[i];
            repeat (HP) @(negedge clk);
            dclk = dclk & ~mask;
            last_fall = cyc;
            repeat (HP) @(negedge clk);
            dclk = dclk | mask;
        end
        @(negedge clk);
        ddat = 2'b11;
    endtask

    task automatic expect_one(input string req, input int n0, input logic [7:0] b,
                              input logic [2:0] flg, input bit chk_lat);
        chk(cap_n == n0 + 1, req, "delivery count", cap_n - n0, 1);
        if (cap_n == n0 + 1) begin
            chk(cap_byte[n0] == b, req, "byte", cap_byte[n0], b);
            chk(cap_flg[n0] == flg, req, "flags {src,tmo,perr}", cap_flg[n0], flg);
            if (chk_lat)
                chk((cap_cyc[n0] - last_fall) >= 3 && (cap_cyc[n0] - last_fall) <= 5,
                    "R9", "latency", cap_cyc[n0] - last_fall, 4);
        end
    endtask

    // {mouse, byte, bad parity}
    localparam logic [9:0] VEC [NV] = '{
        {1'b0, 8'h1C, 1'b0}, {1'b0, 8'h00, 1'b0}, {1'b0, 8'hFF, 1'b0},
        {1'b0, 8'hA5, 1'b1}, {1'b1, 8'h08, 1'b0}, {1'b1, 8'h7E, 1'b1},
        {1'b1, 8'h80, 1'b0}, {1'b0, 8'h01, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n0;
        logic [10:0] f;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        // R10: idle after reset
        chk(rx_valid_o == 1'b0, "R10", "valid after reset", rx_valid_o, 0);
        chk(cap_n == 0, "R10", "no strobe after reset", cap_n, 0);

        // R1 R2 R5 R9: table walk
        for (int v = 0; v < NV; v++) begin
            logic [1:0] m;
            m  = VEC[v][9] ? 2'b10 : 2'b01;
            n0 = cap_n;
            f  = mkframe(VEC[v][8:1], VEC[v][0], 1'b0);
            send(m, f, f, 11);
            repeat (20) @(negedge clk);
            expect_one(VEC[v][0] ? "R2" : (VEC[v][9] ? "R5" : "R1"), n0,
                       VEC[v][8:1], {VEC[v][9], 1'b0, VEC[v][0]}, 1'b1);
        end

        // R6: bad stop bit dropped, next frame fine
        n0 = cap_n;
        send(2'b01, mkframe(8'h3C, 1'b0, 1'b1), '1, 11);
        repeat (20) @(negedge clk);
        chk(cap_n == n0, "R6", "bad stop delivered", cap_n - n0, 0);
        send(2'b01, mkframe(8'h5A, 1'b0, 1'b0), '1, 11);
        repeat (20) @(negedge clk);
        expect_one("R6", n0, 8'h5A, 3'b000, 1'b0);

        // R7: falling edge with data high is not a start
        n0 = cap_n;
        send(2'b10, 11'h7FF, 11'h7FF, 1);
        send(2'b10, '1, mkframe(8'hC3, 1'b0, 1'b0), 11);
        repeat (20) @(negedge clk);
        expect_one("R7", n0, 8'hC3, 3'b100, 1'b0);

        // R3: partial frame times out
        n0 = cap_n;
        send(2'b01, mkframe(8'h11, 1'b0, 1'b0), '1, 4);
        repeat (TMO + 100) @(negedge clk);
        expect_one("R3", n0, 8'hFF, 3'b010, 1'b0);

        // R4: inhibited link drops frames and timeouts, then recovers
        link_en = 1'b0;
        repeat (10) @(negedge clk);
        n0 = cap_n;
        send(2'b10, '1, mkframe(8'h42, 1'b0, 1'b0), 11);
        send(2'b01, mkframe(8'h43, 1'b0, 1'b0), '1, 3);
        repeat (TMO + 100) @(negedge clk);
        chk(cap_n == n0, "R4", "inhibited delivery", cap_n - n0, 0);
        link_en = 1'b1;
        repeat (10) @(negedge clk);
        send(2'b10, '1, mkframe(8'h44, 1'b0, 1'b0), 11);
        repeat (20) @(negedge clk);
        expect_one("R4", n0, 8'h44, 3'b100, 1'b0);

        // R8: both ports finish together
        n0 = cap_n;
        send(2'b11, mkframe(8'h21, 1'b0, 1'b0), mkframe(8'h12, 1'b0, 1'b0), 11);
        repeat (20) @(negedge clk);
        chk(cap_n == n0 + 2, "R8", "two deliveries", cap_n - n0, 2);
        if (cap_n == n0 + 2) begin
            chk(cap_byte[n0] == 8'h21 && cap_flg[n0] == 3'b000, "R8", "first is keyboard",
                cap_byte[n0], 8'h21);
            chk(cap_byte[n0+1] == 8'h12 && cap_flg[n0+1] == 3'b100, "R8", "second is mouse",
                cap_byte[n0+1], 8'h12);
            chk(cap_cyc[n0+1] - cap_cyc[n0] == 1, "R8", "back-to-back strobes",
                cap_cyc[n0+1] - cap_cyc[n0], 1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule